// File: doc/BRIEF.md
# Transmit Descriptor Status and Early-Start Control

This block holds a small ring of 32-bit transmit descriptor words and decides when the frame queued in the current descriptor may begin to leave the transmit FIFO. Software arms a descriptor with one full-word write that carries a frame byte count and an early-start threshold code. That write also wipes the descriptor's result fields and hands ownership back to the hardware side. The block then watches the FIFO fill level and a flag that says a whole frame is already buffered. It issues a one-cycle start request once either condition holds.

Descriptors are served strictly in ring order, and only one frame is in flight at a time. When the MAC signals completion, the block writes the frame's outcome into the in-flight descriptor: good transmit, underrun, abort, carrier loss, late collision and a saturating collision count. It then opens a heartbeat window of fixed length, measured in clock cycles derived from the clock frequency. The window checks that the transceiver produced a collision-detect pulse after the frame. In 100 Mbps mode the missing-heartbeat result is held clear.

Top module: `tx_desc_status`

## Requirements
- R1: A write is accepted only when all four byte enables are high (`wr_be` = 4'b1111); a write with any byte enable low leaves the addressed descriptor word unchanged on readback.
- R2: An accepted write stores bits 12:0 (byte count) and bits 21:16 (threshold code) and clears bits 31:24, bit 15, bit 14 and bit 13 of that descriptor; bits 23:22 always read 0.
- R3: Threshold code 0 means 8 bytes and code N (1..63) means N×32 bytes. For a pending current descriptor, `start_req` is high for exactly one cycle, in the cycle after `fifo_level` is first at or above that byte count, with `start_idx` naming the descriptor.
- R4: When `fifo_eop` is high, a pending current descriptor starts regardless of `fifo_level`.
- R5: Descriptors start in ring order 0,1,2,3,0 after reset or software reset; no further start is issued between a start and the next `tx_done`.
- R6: A `dma_done` pulse sets bit 13 (ownership) of the descriptor named by `dma_idx`.
- R7: On `tx_done` the in-flight descriptor records `tx_crs_lost` in bit 31, `tx_abort` in bit 30, `tx_late_col` in bit 29, `tx_ok` in bit 15 and `tx_underrun` in bit 14.
- R8: Bits 27:24 take `tx_col_count`, saturated to 15 when the input exceeds 15.
- R9: The heartbeat window spans CLK_HZ×64/10,000,000 cycles, starting in the cycle after `tx_done`. At its end, bit 28 of that descriptor is set if `col_det` was never high in the window and left clear if it was.
- R10: When `speed_100` is high at the end of a window, bit 28 stays 0.
- R11: After hard reset every word reads 0. A `sw_rst` pulse clears every bit except bit 13 in all descriptors, drops pending starts and returns the ring pointer to descriptor 0.
- R12: Ones written to bits 31:24, 23:22 or 15:13 by an accepted write read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_rst | input | 1 | Synchronous software reset pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Descriptor index for the write |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Descriptor index for the read |
| rd_data | output | 32 | Selected descriptor word (combinational) |
| fifo_level | input | 12 | Bytes currently held in the transmit FIFO |
| fifo_eop | input | 1 | FIFO holds at least one complete frame |
| start_req | output | 1 | One-cycle request to start transmission |
| start_idx | output | 2 | Descriptor that the start request belongs to |
| dma_done | input | 1 | Frame of a descriptor fully moved into the FIFO |
| dma_idx | input | 2 | Descriptor index for `dma_done` |
| tx_done | input | 1 | MAC completion pulse for the in-flight frame |
| tx_ok | input | 1 | Frame sent without error |
| tx_underrun | input | 1 | FIFO ran dry during the frame |
| tx_abort | input | 1 | Frame was aborted |
| tx_crs_lost | input | 1 | Carrier dropped during the frame |
| tx_late_col | input | 1 | Collision outside the legal window |
| tx_col_count | input | 5 | Collisions seen for the frame |
| col_det | input | 1 | Collision-detect signal from the transceiver |
| speed_100 | input | 1 | Link runs at 100 Mbps |

## Verification
The assertions assume that `tx_done` arrives only while a frame is in flight. They also assume that `dma_idx`, `wr_sel` and `rd_sel` name existing descriptors, and that completion pulses are one cycle wide. The stimulus raises `tx_done` only after it has seen the matching start request. It lets each heartbeat window run out before the next completion, so no window is restarted part-way. It holds `speed_100` steady across a whole window, so the forced-clear rule is checked on a window that was opened and closed in the same mode.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

  // Bit positions the neighbouring software and MAC decode
  localparam int TSD_CNT_W   = 13;
  localparam int TSD_THR_LSB = 16;
  localparam int TSD_THR_W   = 6;
  localparam int TSD_NCC_W   = 4;

  typedef enum logic [0:0] {
    ES_IDLE = 1'b0,
    ES_SEND = 1'b1
  } es_state_e;

  // Outcome flags reported by the MAC for one frame
  typedef struct packed {
    logic crs_lost;
    logic aborted;
    logic late_col;
    logic tx_ok;
    logic underrun;
  } tsd_result_t;

  // Threshold code to byte count: 0 -> 8 bytes, N -> N*32 bytes
  function automatic logic [11:0] thr_bytes(input logic [TSD_THR_W-1:0] code);
    if (code == '0) thr_bytes = 12'd8;
    else            thr_bytes = {1'b0, code, 5'b00000};
  endfunction

endpackage

// File: rtl/tsd_slot.sv
module tsd_slot
  import tsd_pkg::*;
#(
  parameter int COLIN_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sw_rst,
  input  logic                  wr_hit,
  input  logic                  wr_part,
  input  logic [31:0]           wr_data,
  input  logic                  take_hit,
  input  logic                  done_hit,
  input  tsd_result_t           done_res,
  input  logic [COLIN_W-1:0]    col_in,
  input  logic                  dma_hit,
  input  logic                  hb_hit,
  input  logic                  hb_missing,
  output logic                  pending,
  output logic [TSD_THR_W-1:0]  thr_code,
  output logic [31:0]           rd_word
);

  logic [TSD_CNT_W-1:0] cnt_q, cnt_d;
  logic [TSD_THR_W-1:0] thr_q, thr_d;
  logic [TSD_NCC_W-1:0] ncc_q, ncc_d;
  logic                 own_q, own_d;
  logic                 cdh_q, cdh_d;
  logic                 pend_q, pend_d;
  tsd_result_t          res_q, res_d;
  logic [TSD_NCC_W-1:0] ncc_sat;

  assign ncc_sat = (col_in > COLIN_W'(15)) ? 4'hF : col_in[TSD_NCC_W-1:0];

  always_comb begin
    cnt_d  = cnt_q;
    thr_d  = thr_q;
    ncc_d  = ncc_q;
    own_d  = own_q;
    cdh_d  = cdh_q;
    pend_d = pend_q;
    res_d  = res_q;
    if (dma_hit)  own_d  = 1'b1;
    if (take_hit) pend_d = 1'b0;
    if (done_hit) begin
      res_d = done_res;
      ncc_d = ncc_sat;
    end
    if (hb_hit) cdh_d = hb_missing;
    if (wr_hit) begin
      cnt_d  = wr_data[TSD_CNT_W-1:0];
      thr_d  = wr_data[TSD_THR_LSB +: TSD_THR_W];
      ncc_d  = '0;
      own_d  = 1'b0;
      cdh_d  = 1'b0;
      res_d  = '0;
      pend_d = 1'b1;
    end
    if (sw_rst) begin
      cnt_d  = '0;
      thr_d  = '0;
      ncc_d  = '0;
      cdh_d  = 1'b0;
      res_d  = '0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      thr_q  <= '0;
      ncc_q  <= '0;
      own_q  <= 1'b0;
      cdh_q  <= 1'b0;
      pend_q <= 1'b0;
      res_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      thr_q  <= thr_d;
      ncc_q  <= ncc_d;
      own_q  <= own_d;
      cdh_q  <= cdh_d;
      pend_q <= pend_d;
      res_q  <= res_d;
    end
  end

  assign pending  = pend_q;
  assign thr_code = thr_q;
  assign rd_word  = {res_q.crs_lost, res_q.aborted, res_q.late_col, cdh_q, ncc_q,
                     2'b00, thr_q, res_q.tx_ok, res_q.underrun, own_q, cnt_q};

  // R1: a narrow write leaves the word untouched
  assert_partial_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_part && !wr_hit && !done_hit && !dma_hit && !hb_hit && !sw_rst && !take_hit)
      |=> $stable(rd_word));

  // R2: a full write clears results and ownership
  assert_write_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !sw_rst) |=> (rd_word[31:24] == 8'h00 && rd_word[15:13] == 3'b000));

  // R8: collision count saturates
  assert_ncc_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_hit && !wr_hit && !sw_rst && col_in > COLIN_W'(15)) |=> rd_word[27:24] == 4'hF);

  // R11: software reset keeps ownership
  assert_swrst_keeps_own_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rst && !wr_hit && !dma_hit) |=> (rd_word[13] == $past(rd_word[13]) &&
                                         rd_word[31:14] == 18'h0 && rd_word[12:0] == 13'h0));

endmodule

// File: rtl/tsd_early_start.sv
module tsd_early_start
  import tsd_pkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int LVL_W    = 12,
  localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                sw_rst,
  input  logic [NUM_DESC-1:0]                 pending,
  input  logic [NUM_DESC-1:0][TSD_THR_W-1:0]  thr_codes,
  input  logic [LVL_W-1:0]                    fifo_level,
  input  logic                                fifo_eop,
  input  logic                                tx_done,
  output logic                                start_req,
  output logic [IDX_W-1:0]                    start_idx,
  output logic [NUM_DESC-1:0]                 take,
  output logic [NUM_DESC-1:0]                 done_vec,
  output logic [IDX_W-1:0]                    cur_idx,
  output logic                                done_any
);

  es_state_e        state_q, state_d;
  logic [IDX_W-1:0] cur_q, cur_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             start_q, start_d;
  logic [LVL_W-1:0] need;
  logic             fill_ok;
  logic             go;
  logic             fin;

  assign need    = LVL_W'(thr_bytes(thr_codes[cur_q]));
  assign fill_ok = fifo_eop || (fifo_level >= need);
  assign go      = (state_q == ES_IDLE) && pending[cur_q] && fill_ok && !sw_rst;
  assign fin     = (state_q == ES_SEND) && tx_done && !sw_rst;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    idx_d   = idx_q;
    start_d = 1'b0;
    if (sw_rst) begin
      state_d = ES_IDLE;
      cur_d   = '0;
    end else if (go) begin
      state_d = ES_SEND;
      start_d = 1'b1;
      idx_d   = cur_q;
    end else if (fin) begin
      state_d = ES_IDLE;
      if (cur_q == IDX_W'(NUM_DESC-1)) cur_d = '0;
      else                             cur_d = cur_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ES_IDLE;
      cur_q   <= '0;
      idx_q   <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      idx_q   <= idx_d;
      start_q <= start_d;
    end
  end

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_sel
    assign take[g]     = go  && (cur_q == IDX_W'(g));
    assign done_vec[g] = fin && (cur_q == IDX_W'(g));
  end

  assign start_req = start_q;
  assign start_idx = idx_q;
  assign cur_idx   = cur_q;
  assign done_any  = fin;

  // R3: the start request is a single-cycle pulse
  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> !start_req);

  // R5: nothing starts while a frame is in flight
  assert_no_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ES_SEND) |=> !start_req);

  // R5: a start always names the descriptor then at the ring pointer
  assert_start_in_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> (start_idx == cur_q));

endmodule

// File: rtl/tsd_heartbeat.sv
module tsd_heartbeat #(
  parameter int WIN_CYCLES = 1600,
  parameter int IDX_W      = 2,
  localparam int CNT_W     = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             open_win,
  input  logic [IDX_W-1:0] open_idx,
  input  logic             col_det,
  input  logic             speed_100,
  output logic             hb_fire,
  output logic [IDX_W-1:0] hb_idx,
  output logic             hb_missing
);

  logic             act_q, act_d;
  logic             seen_q, seen_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last;

  assign last = act_q && (cnt_q == CNT_W'(WIN_CYCLES-1));

  always_comb begin
    act_d  = act_q;
    seen_d = seen_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    if (sw_rst) begin
      act_d  = 1'b0;
      seen_d = 1'b0;
      cnt_d  = '0;
    end else if (open_win) begin
      act_d  = 1'b1;
      seen_d = 1'b0;
      cnt_d  = '0;
      idx_d  = open_idx;
    end else if (act_q) begin
      seen_d = seen_q | col_det;
      if (last) act_d = 1'b0;
      else      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else begin
      act_q  <= act_d;
      seen_q <= seen_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
    end
  end

  assign hb_fire    = last && !sw_rst && !open_win;
  assign hb_idx     = idx_q;
  assign hb_missing = !(seen_q || col_det) && !speed_100;

  // R9: the window counter stays inside the window
  assert_window_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q <= CNT_W'(WIN_CYCLES-1)));

  // R9: every window starts counting from zero
  assert_window_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> (cnt_q == '0));

endmodule

// File: rtl/tx_desc_status.sv
module tx_desc_status
  import tsd_pkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int CLK_HZ   = 250_000_000,
  parameter int LVL_W    = 12,
  parameter int COLIN_W  = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sw_rst,
  input  logic                         wr_en,
  input  logic [$clog2(NUM_DESC)-1:0]  wr_sel,
  input  logic [3:0]                   wr_be,
  input  logic [31:0]                  wr_data,
  input  logic [$clog2(NUM_DESC)-1:0]  rd_sel,
  output logic [31:0]                  rd_data,
  input  logic [LVL_W-1:0]             fifo_level,
  input  logic                         fifo_eop,
  output logic                         start_req,
  output logic [$clog2(NUM_DESC)-1:0]  start_idx,
  input  logic                         dma_done,
  input  logic [$clog2(NUM_DESC)-1:0]  dma_idx,
  input  logic                         tx_done,
  input  logic                         tx_ok,
  input  logic                         tx_underrun,
  input  logic                         tx_abort,
  input  logic                         tx_crs_lost,
  input  logic                         tx_late_col,
  input  logic [COLIN_W-1:0]           tx_col_count,
  input  logic                         col_det,
  input  logic                         speed_100
);

  localparam int    IDX_W  = $clog2(NUM_DESC);
  localparam longint HB_L  = (longint'(CLK_HZ) * 64) / 10_000_000;
  localparam int    HB_CYC = (HB_L < 1) ? 1 : int'(HB_L);

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic                                wr_full;
  logic                                wr_part;
  logic [NUM_DESC-1:0]                 pend_vec;
  logic [NUM_DESC-1:0][TSD_THR_W-1:0]  thr_vec;
  logic [NUM_DESC-1:0]                 take_vec;
  logic [NUM_DESC-1:0]                 done_vec;
  logic [IDX_W-1:0]                    cur_idx;
  logic                                done_any;
  logic                                hb_fire;
  logic [IDX_W-1:0]                    hb_idx;
  logic                                hb_missing;
  logic [31:0]                         slot_word [NUM_DESC];
  tsd_result_t                         res_in;

  assign wr_full = wr_en && (wr_be == 4'hF);
  assign wr_part = wr_en && (wr_be != 4'hF);

  assign res_in.crs_lost = tx_crs_lost;
  assign res_in.aborted  = tx_abort;
  assign res_in.late_col = tx_late_col;
  assign res_in.tx_ok    = tx_ok;
  assign res_in.underrun = tx_underrun;

  tsd_early_start #(
    .NUM_DESC (NUM_DESC),
    .LVL_W    (LVL_W)
  ) u_start (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .sw_rst     (sw_rst),
    .pending    (pend_vec),
    .thr_codes  (thr_vec),
    .fifo_level (fifo_level),
    .fifo_eop   (fifo_eop),
    .tx_done    (tx_done),
    .start_req  (start_req),
    .start_idx  (start_idx),
    .take       (take_vec),
    .done_vec   (done_vec),
    .cur_idx    (cur_idx),
    .done_any   (done_any)
  );

  tsd_heartbeat #(
    .WIN_CYCLES (HB_CYC),
    .IDX_W      (IDX_W)
  ) u_hb (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .sw_rst     (sw_rst),
    .open_win   (done_any),
    .open_idx   (cur_idx),
    .col_det    (col_det),
    .speed_100  (speed_100),
    .hb_fire    (hb_fire),
    .hb_idx     (hb_idx),
    .hb_missing (hb_missing)
  );

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_slot
    logic sel_wr;
    assign sel_wr = (wr_sel == IDX_W'(g));

    tsd_slot #(
      .COLIN_W (COLIN_W)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_core_n),
      .sw_rst     (sw_rst),
      .wr_hit     (wr_full && sel_wr),
      .wr_part    (wr_part && sel_wr),
      .wr_data    (wr_data),
      .take_hit   (take_vec[g]),
      .done_hit   (done_vec[g]),
      .done_res   (res_in),
      .col_in     (tx_col_count),
      .dma_hit    (dma_done && (dma_idx == IDX_W'(g))),
      .hb_hit     (hb_fire && (hb_idx == IDX_W'(g))),
      .hb_missing (hb_missing),
      .pending    (pend_vec[g]),
      .thr_code   (thr_vec[g]),
      .rd_word    (slot_word[g])
    );
  end

  assign rd_data = slot_word[rd_sel];

  // R10: a window that closes in 100 Mbps mode leaves the heartbeat bit clear
  assert_fast_mode_clear_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (hb_fire && speed_100 && !sw_rst && !(wr_full && wr_sel == hb_idx))
      |=> (slot_word[$past(hb_idx)][28] == 1'b0));

endmodule

// File: tb/tx_desc_status_test.sv
module tx_desc_status_test;

  localparam int WIN = 1600;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_rst;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [3:0]  wr_be;
  logic [31:0] wr_data;
  logic [1:0]  rd_sel;
  logic [31:0] rd_data;
  logic [11:0] fifo_level;
  logic        fifo_eop;
  logic        start_req;
  logic [1:0]  start_idx;
  logic        dma_done;
  logic [1:0]  dma_idx;
  logic        tx_done;
  logic        tx_ok;
  logic        tx_underrun;
  logic        tx_abort;
  logic        tx_crs_lost;
  logic        tx_late_col;
  logic [4:0]  tx_col_count;
  logic        col_det;
  logic        speed_100;

  int n_checks = 0;
  int n_fail   = 0;
  int n_starts = 0;
  logic [1:0] last_idx = 2'd0;

  always #2 clk = ~clk;

  tx_desc_status uut (
    .clk (clk), .rst_n (rst_n), .sw_rst (sw_rst),
    .wr_en (wr_en), .wr_sel (wr_sel), .wr_be (wr_be), .wr_data (wr_data),
    .rd_sel (rd_sel), .rd_data (rd_data),
    .fifo_level (fifo_level), .fifo_eop (fifo_eop),
    .start_req (start_req), .start_idx (start_idx),
    .dma_done (dma_done), .dma_idx (dma_idx),
    .tx_done (tx_done), .tx_ok (tx_ok), .tx_underrun (tx_underrun),
    .tx_abort (tx_abort), .tx_crs_lost (tx_crs_lost), .tx_late_col (tx_late_col),
    .tx_col_count (tx_col_count), .col_det (col_det), .speed_100 (speed_100)
  );

  // Count start pulses as seen just before each rising edge
  always @(posedge clk) begin
    if (start_req) begin
      n_starts <= n_starts + 1;
      last_idx <= start_idx;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] idx, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = idx; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 4'h0;
  endtask

  task automatic reg_check(input logic [1:0] idx, input logic [31:0] exp, input string req);
    rd_sel = idx;
    #1;
    chk(rd_data === exp, req, rd_data, exp);
  endtask

  task automatic finish_frame(input logic ok, input logic unr, input logic abt,
                              input logic crs, input logic owc, input logic [4:0] cols);
    @(negedge clk);
    tx_done = 1'b1; tx_ok = ok; tx_underrun = unr; tx_abort = abt;
    tx_crs_lost = crs; tx_late_col = owc; tx_col_count = cols;
    @(negedge clk);
    tx_done = 1'b0; tx_ok = 1'b0; tx_underrun = 1'b0; tx_abort = 1'b0;
    tx_crs_lost = 1'b0; tx_late_col = 1'b0; tx_col_count = 5'd0;
  endtask

  task automatic pulse_dma(input logic [1:0] idx);
    @(negedge clk);
    dma_done = 1'b1; dma_idx = idx;
    @(negedge clk);
    dma_done = 1'b0;
  endtask

  task automatic test_reset;
    for (int i = 0; i < 4; i++) reg_check(2'(i), 32'h0, "R11 reset value");
    chk(n_starts == 0, "R11 no start after reset", 32'(n_starts), 32'd0);
  endtask

  task automatic test_write_fields;
    // Ones in result, reserved and ownership bits must be dropped
    reg_write(2'd0, 4'hF, 32'hFFC5_E040);
    reg_check(2'd0, 32'h0005_0040, "R2 R12 stored fields");
    reg_write(2'd0, 4'b0111, 32'h0000_0001);
    reg_check(2'd0, 32'h0005_0040, "R1 partial write ignored");
  endtask

  task automatic test_threshold;
    // code 5 -> 160 bytes
    fifo_level = 12'd159;
    tick(5);
    chk(n_starts == 0, "R3 below threshold", 32'(n_starts), 32'd0);
    fifo_level = 12'd160;
    tick(3);
    chk(n_starts == 1, "R3 start at threshold", 32'(n_starts), 32'd1);
    chk(last_idx == 2'd0, "R3 start index", 32'(last_idx), 32'd0);
    tick(4);
    chk(n_starts == 1, "R3 single pulse", 32'(n_starts), 32'd1);
  endtask

  task automatic test_busy;
    reg_write(2'd1, 4'hF, 32'h0000_0020);
    tick(5);
    chk(n_starts == 1, "R5 no start while in flight", 32'(n_starts), 32'd1);
  endtask

  task automatic test_complete;
    fifo_level = 12'd7;
    finish_frame(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 5'd20);
    tick(2);
    reg_check(2'd0, 32'hCF05_8040, "R7 R8 results recorded");
    chk(n_starts == 1, "R3 code 0 needs 8 bytes", 32'(n_starts), 32'd1);
    fifo_level = 12'd8;
    tick(3);
    chk(n_starts == 2, "R3 R5 next descriptor starts", 32'(n_starts), 32'd2);
    chk(last_idx == 2'd1, "R5 ring order", 32'(last_idx), 32'd1);
  endtask

  task automatic test_hb_missing;
    tick(WIN + 100);
    reg_check(2'd0, 32'hDF05_8040, "R9 heartbeat missing");
  endtask

  task automatic test_hb_seen;
    pulse_dma(2'd1);
    reg_check(2'd1, 32'h0000_2020, "R6 ownership set");
    finish_frame(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2);
    tick(100);
    col_det = 1'b1;
    tick(1);
    col_det = 1'b0;
    tick(WIN + 100);
    reg_check(2'd1, 32'h0200_A020, "R9 heartbeat seen");
  endtask

  task automatic test_fast_mode;
    reg_write(2'd2, 4'hF, 32'h0001_0010);
    tick(4);
    chk(n_starts == 2, "R3 code 1 needs 32 bytes", 32'(n_starts), 32'd2);
    fifo_eop = 1'b1;
    tick(3);
    chk(n_starts == 3, "R4 complete frame starts", 32'(n_starts), 32'd3);
    chk(last_idx == 2'd2, "R4 start index", 32'(last_idx), 32'd2);
    fifo_eop = 1'b0;
    speed_100 = 1'b1;
    finish_frame(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0);
    tick(WIN + 100);
    reg_check(2'd2, 32'h0001_4010, "R10 heartbeat clear at 100M");
    speed_100 = 1'b0;
  endtask

  task automatic test_sw_reset;
    pulse_dma(2'd2);
    reg_check(2'd2, 32'h0001_6010, "R6 ownership set");
    reg_write(2'd3, 4'hF, 32'h0002_0000);
    tick(3);
    chk(n_starts == 3, "R3 code 2 needs 64 bytes", 32'(n_starts), 32'd3);
    @(negedge clk);
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    reg_check(2'd0, 32'h0000_0000, "R11 soft reset slot 0");
    reg_check(2'd1, 32'h0000_2000, "R11 soft reset keeps own");
    reg_check(2'd2, 32'h0000_2000, "R11 soft reset keeps own");
    reg_check(2'd3, 32'h0000_0000, "R11 soft reset slot 3");
    fifo_level = 12'd2000;
    tick(5);
    chk(n_starts == 3, "R11 pending dropped", 32'(n_starts), 32'd3);
    reg_write(2'd0, 4'hF, 32'h0000_0001);
    tick(3);
    chk(n_starts == 4, "R5 R11 pointer back at 0", 32'(n_starts), 32'd4);
    chk(last_idx == 2'd0, "R5 restart index", 32'(last_idx), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; sw_rst = 1'b0;
    wr_en = 1'b0; wr_sel = 2'd0; wr_be = 4'h0; wr_data = 32'h0; rd_sel = 2'd0;
    fifo_level = 12'd0; fifo_eop = 1'b0;
    dma_done = 1'b0; dma_idx = 2'd0;
    tx_done = 1'b0; tx_ok = 1'b0; tx_underrun = 1'b0; tx_abort = 1'b0;
    tx_crs_lost = 1'b0; tx_late_col = 1'b0; tx_col_count = 5'd0;
    col_det = 1'b0; speed_100 = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(4);
    test_reset();
    test_write_fields();
    test_threshold();
    test_busy();
    test_complete();
    test_hb_missing();
    test_hb_seen();
    test_fast_mode();
    test_sw_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got %h expected %h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule